// File: doc/BRIEF.md
# Base Address Register Bank

This block holds the base address registers of one configuration header, plus the command register whose two space-enable bits turn their decode on and off. Each register has a size and a space type (I/O or memory), both fixed by parameters. A register with size zero is not implemented. Software finds a register's size by writing all ones and reading back the value. It then writes the base it has chosen.

The configuration access decoder drives a dword-wide write/read port, selected by dword index. The command register sits at dword 1 and the registers occupy dwords 4 upward. For every register, the block reports whether its decode is active. It also reports whether the bus address currently presented falls inside that register's window, for the given space type.

Top module: `bar_bank`

## Requirements
- R1: After reset the command register reads 0, no register is active, no hit is reported, and each implemented register reads only its type bits. For I/O the type bits are bit 0 = 1 and bit 1 = 0. For memory they are bit 0 = 0, bits 2:1 = 00 and bit 3 = the prefetchable parameter.
- R2: Writing 0xFFFFFFFF to an implemented register makes it read back ~(size-1) in the address bits, together with the type bits.
- R3: The type bits (bits 1:0 for I/O, bits 3:0 for memory) never change under any write, whether sizing or normal.
- R4: Address bits below the register size are hardwired to 0, so a stored base is always naturally aligned.
- R5: A register of size 0 always reads 0, ignores writes, and never becomes active or reports a hit.
- R6: The command register at dword 1 stores bits 15:0 of a write, and its upper 16 bits read 0. Bit 0 enables I/O space and bit 1 enables memory space.
- R7: An implemented register is active exactly when the enable bit of its space type is set. A command write that flips an enable bit activates or deactivates every register of that type.
- R8: Writing a register updates only its stored value and never changes any activation. This holds whether its space is enabled or disabled.
- R9: A register reports a hit when all of the following hold: it is active, bus_io equals its type (1 = I/O), and bus_addr with the bits below the size cleared equals its stored base.
- R10: A write to any dword index other than 1 or 4..(3+NUM_BARS) has no effect, and a read of such an index returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Configuration dword index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data of the selected dword (combinational) |
| bus_io | input | 1 | Bus access space: 1 = I/O, 0 = memory |
| bus_addr | input | 32 | Bus address to match |
| bar_active | output | NUM_BARS | Decode active, one bit per register |
| bar_hit | output | NUM_BARS | Address match, one bit per register |

## Verification
The assertions assume that cfg_sel and cfg_wdata carry a full dword on every write. They also assume that the decoder issues at most one configuration write per cycle, so a command write and a register write never coincide. The stimulus holds cfg_wr for exactly one cycle at a time and otherwise leaves the port idle. It changes the bus inputs only on the falling edge. Addresses are chosen both inside and one byte past each window, and in both space types, so that the hit comparison is exercised on either side of the boundary.

// File: rtl/bar_bank_pkg.sv
`timescale 1ns/1ps
package bar_bank_pkg;
   localparam int DATA_W     = 32;
   localparam int CMD_DW     = 1;
   localparam int BAR0_DW    = 4;
   localparam int CMD_IO_EN  = 0;
   localparam int CMD_MEM_EN = 1;
   localparam logic [31:0] CMD_KEEP = 32'h0000_FFFF;

   // read-only low bits of a register, by space type
   function automatic logic [31:0] flag_mask(input logic is_io);
      return is_io ? 32'h0000_0003 : 32'h0000_000F;
   endfunction

   function automatic logic [31:0] type_bits(input logic is_io, input logic pref);
      return is_io ? 32'h0000_0001 : {28'd0, pref, 3'b000};
   endfunction
endpackage

// File: rtl/bar_cmd_reg.sv
`timescale 1ns/1ps
module bar_cmd_reg
   import bar_bank_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [31:0] wdata,
   output logic [31:0] cmd_q,
   output logic        io_tog,
   output logic        mem_tog
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cmd_q <= '0;
      else if (wr_en) cmd_q <= wdata & CMD_KEEP;
   end

   // a flip of an enable bit on this write
   assign io_tog  = wr_en && (wdata[CMD_IO_EN]  != cmd_q[CMD_IO_EN]);
   assign mem_tog = wr_en && (wdata[CMD_MEM_EN] != cmd_q[CMD_MEM_EN]);
endmodule

// File: rtl/bar_slot.sv
`timescale 1ns/1ps
module bar_slot
   import bar_bank_pkg::*;
#(
   parameter logic [31:0] SIZE  = 32'h1000,
   parameter bit          IS_IO = 1'b0,
   parameter bit          PREF  = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [31:0] wdata,
   input  logic        tog,
   input  logic        en_new,
   input  logic        bus_io,
   input  logic [31:0] bus_addr,
   output logic [31:0] rdata,
   output logic        active,
   output logic        hit
);
   localparam logic [31:0] KEEP  = ~(SIZE - 32'd1) & ~flag_mask(IS_IO);
   localparam logic [31:0] TBITS = type_bits(IS_IO, PREF);

   logic [31:0] base_q;
   logic        active_q;

   // an all-ones write leaves exactly ~(size-1) in the address bits
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     base_q <= '0;
      else if (wr_en) base_q <= wdata & KEEP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   active_q <= 1'b0;
      else if (tog) active_q <= en_new;
   end

   assign rdata  = base_q | TBITS;
   assign active = active_q;
   assign hit    = active_q && (bus_io == IS_IO) && ((bus_addr & KEEP) == base_q);
endmodule

// File: rtl/bar_bank.sv
`timescale 1ns/1ps
module bar_bank
   import bar_bank_pkg::*;
#(
   parameter int NUM_BARS = 6,
   parameter int SEL_W    = 6,
   parameter logic [NUM_BARS-1:0][31:0] BAR_SIZE =
      {32'h0, 32'h100, 32'h1_0000, 32'h0, 32'h1000, 32'h20},
   parameter logic [NUM_BARS-1:0] BAR_IS_IO = 6'b010001,
   parameter logic [NUM_BARS-1:0] BAR_PREF  = 6'b001000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_wr,
   input  logic [SEL_W-1:0]    cfg_sel,
   input  logic [31:0]         cfg_wdata,
   output logic [31:0]         cfg_rdata,
   input  logic                bus_io,
   input  logic [31:0]         bus_addr,
   output logic [NUM_BARS-1:0] bar_active,
   output logic [NUM_BARS-1:0] bar_hit
);
   localparam int LAST_DW = BAR0_DW + NUM_BARS - 1;

   if (NUM_BARS < 1 || LAST_DW >= (1 << SEL_W))
      $error("bar_bank: register map does not fit the select width");

   logic [31:0] cmd_q;
   logic        io_tog, mem_tog;
   logic [31:0] bar_rd [NUM_BARS];

   bar_cmd_reg u_cmd (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr && cfg_sel == SEL_W'(CMD_DW)),
      .wdata   (cfg_wdata),
      .cmd_q   (cmd_q),
      .io_tog  (io_tog),
      .mem_tog (mem_tog)
   );

   for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
      if (BAR_SIZE[i] == 32'd0) begin : g_none
         assign bar_rd[i]     = '0;
         assign bar_active[i] = 1'b0;
         assign bar_hit[i]    = 1'b0;
      end else begin : g_impl
         if ((BAR_SIZE[i] & (BAR_SIZE[i] - 32'd1)) != 32'd0)
            $error("bar_bank: register size must be a power of two");
         if (BAR_IS_IO[i] && BAR_SIZE[i] < 32'd4)
            $error("bar_bank: I/O register smaller than 4 bytes");
         if (!BAR_IS_IO[i] && BAR_SIZE[i] < 32'd16)
            $error("bar_bank: memory register smaller than 16 bytes");

         bar_slot #(
            .SIZE  (BAR_SIZE[i]),
            .IS_IO (BAR_IS_IO[i]),
            .PREF  (BAR_PREF[i])
         ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (cfg_wr && cfg_sel == SEL_W'(BAR0_DW + i)),
            .wdata    (cfg_wdata),
            .tog      (BAR_IS_IO[i] ? io_tog : mem_tog),
            .en_new   (BAR_IS_IO[i] ? cfg_wdata[CMD_IO_EN] : cfg_wdata[CMD_MEM_EN]),
            .bus_io   (bus_io),
            .bus_addr (bus_addr),
            .rdata    (bar_rd[i]),
            .active   (bar_active[i]),
            .hit      (bar_hit[i])
         );
      end
   end

   always_comb begin
      cfg_rdata = '0;
      if (cfg_sel == SEL_W'(CMD_DW)) cfg_rdata = cmd_q;
      for (int i = 0; i < NUM_BARS; i++)
         if (cfg_sel == SEL_W'(BAR0_DW + i)) cfg_rdata = bar_rd[i];
   end
endmodule

// File: rtl/bar_bank_chk.sv
`timescale 1ns/1ps
module bar_bank_chk
   import bar_bank_pkg::*;
#(
   parameter int NUM_BARS = 6,
   parameter int SEL_W    = 6,
   parameter logic [NUM_BARS-1:0][31:0] BAR_SIZE = '0,
   parameter logic [NUM_BARS-1:0] BAR_IS_IO = '0,
   parameter logic [NUM_BARS-1:0] BAR_PREF  = '0
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cfg_wr,
   input logic [SEL_W-1:0]    cfg_sel,
   input logic [31:0]         cfg_rdata,
   input logic                bus_io,
   input logic [NUM_BARS-1:0] bar_active,
   input logic [NUM_BARS-1:0] bar_hit,
   input logic [31:0]         cmd
);
   logic bar_wr;
   assign bar_wr = cfg_wr && (cfg_sel >= SEL_W'(BAR0_DW)) &&
                   (cfg_sel < SEL_W'(BAR0_DW + NUM_BARS));

   a_r9_hit_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
      (bar_hit & ~bar_active) == '0);

   a_r9_hit_space_type: assert property (@(posedge clk) disable iff (!rst_n)
      bus_io |-> (bar_hit & ~BAR_IS_IO) == '0);

   a_r8_write_keeps_activation: assert property (@(posedge clk) disable iff (!rst_n)
      bar_wr |=> $stable(bar_active));

   a_r6_cmd_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_sel == SEL_W'(CMD_DW)) |-> (cfg_rdata[31:16] == 16'd0));

   for (genvar i = 0; i < NUM_BARS; i++) begin : g_chk
      if (BAR_SIZE[i] == 32'd0) begin : g_none
         a_r5_unimpl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_sel == SEL_W'(BAR0_DW + i)) |-> (cfg_rdata == 32'd0));
      end else begin : g_impl
         a_r7_active_follows_enable: assert property (@(posedge clk) disable iff (!rst_n)
            bar_active[i] == (BAR_IS_IO[i] ? cmd[CMD_IO_EN] : cmd[CMD_MEM_EN]));
         a_r3_type_bits_fixed: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_sel == SEL_W'(BAR0_DW + i)) |->
            ((cfg_rdata & flag_mask(BAR_IS_IO[i])) == type_bits(BAR_IS_IO[i], BAR_PREF[i])));
      end
   end
endmodule

bind bar_bank bar_bank_chk #(
   .NUM_BARS  (NUM_BARS),
   .SEL_W     (SEL_W),
   .BAR_SIZE  (BAR_SIZE),
   .BAR_IS_IO (BAR_IS_IO),
   .BAR_PREF  (BAR_PREF)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_wr     (cfg_wr),
   .cfg_sel    (cfg_sel),
   .cfg_rdata  (cfg_rdata),
   .bus_io     (bus_io),
   .bar_active (bar_active),
   .bar_hit    (bar_hit),
   .cmd        (cmd_q)
);

// File: tb/sim_bar_bank.sv
`timescale 1ns/1ps
module sim_bar_bank;
   localparam int NB = 6;
   localparam logic [NB-1:0][31:0] SZ =
      {32'h0, 32'h100, 32'h1_0000, 32'h0, 32'h1000, 32'h20};
   localparam logic [NB-1:0] IO = 6'b010001;
   localparam logic [NB-1:0] PF = 6'b001000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [5:0]    cfg_sel = '0;
   logic [31:0]   cfg_wdata = '0;
   logic [31:0]   cfg_rdata;
   logic          bus_io = 1'b0;
   logic [31:0]   bus_addr = '0;
   logic [NB-1:0] bar_active, bar_hit;

   always #10 clk = ~clk;

   bar_bank #(.NUM_BARS(NB), .SEL_W(6), .BAR_SIZE(SZ), .BAR_IS_IO(IO), .BAR_PREF(PF)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_io(bus_io),
      .bus_addr(bus_addr), .bar_active(bar_active), .bar_hit(bar_hit));

   typedef struct {
      int          kind;   // 0 read data, 1 active vector, 2 hit vector
      logic [31:0] exp;
      string       req;
   } item_t;

   item_t q[$];
   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // expected register contents from R2..R5
   function automatic logic [31:0] exp_bar(input int i, input logic [31:0] w);
      logic [31:0] low;
      if (SZ[i] == 32'd0) return 32'd0;
      low = IO[i] ? 32'h3 : 32'hF;
      return (w & ~(SZ[i] - 32'd1) & ~low) | (IO[i] ? 32'h1 : {28'd0, PF[i], 3'b000});
   endfunction

   task automatic cfg_write(input logic [5:0] sel, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic look(input logic [5:0] sel, input logic io, input logic [31:0] addr,
                       input logic [31:0] e_rd, input logic [NB-1:0] e_act,
                       input logic [NB-1:0] e_hit, input string req);
      @(negedge clk);
      cfg_wr = 1'b0; cfg_sel = sel; bus_io = io; bus_addr = addr;
      q.push_back('{0, e_rd, req});
      q.push_back('{1, 32'(e_act), req});
      q.push_back('{2, 32'(e_hit), req});
      @(posedge clk);
   endtask

   // monitor: compares a quarter period after the edge, inputs steady
   initial begin
      forever begin
         @(posedge clk);
         #5;
         while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            act = (it.kind == 0) ? cfg_rdata :
                  (it.kind == 1) ? 32'(bar_active) : 32'(bar_hit);
            n_chk++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      look(6'd1, 1'b0, 32'h0, 32'h0, '0, '0, "R1 cmd");
      for (int i = 0; i < NB; i++)
         look(6'(4 + i), 1'b0, 32'h0, exp_bar(i, 32'h0), '0, '0, "R1 bar");

      // R2 size probe, R5 unimplemented, R8 no activation
      for (int i = 0; i < NB; i++) cfg_write(6'(4 + i), 32'hFFFF_FFFF);
      look(6'd4, 1'b0, 32'h0, 32'hFFFF_FFE1, '0, '0, "R2 io probe");
      look(6'd5, 1'b0, 32'h0, 32'hFFFF_F000, '0, '0, "R2 mem probe");
      look(6'd7, 1'b0, 32'h0, 32'hFFFF_0008, '0, '0, "R2 pref probe");
      look(6'd8, 1'b0, 32'h0, 32'hFFFF_FF01, '0, '0, "R2 io256 probe");
      look(6'd6, 1'b0, 32'h0, 32'h0, '0, '0, "R5 unimpl probe");

      // R3 R4 bases with junk low bits, R8 space disabled
      cfg_write(6'd4, 32'h0000_C0FF);
      cfg_write(6'd5, 32'h8000_1ABC);
      cfg_write(6'd6, 32'h1234_5678);
      cfg_write(6'd7, 32'h9001_234F);
      cfg_write(6'd8, 32'h0000_D033);
      look(6'd4, 1'b1, 32'h0000_C0E0, 32'h0000_C0E1, '0, '0, "R3 io base");
      look(6'd5, 1'b0, 32'h8000_1000, 32'h8000_1000, '0, '0, "R8 disabled no hit");
      look(6'd7, 1'b0, 32'h0, 32'h9001_0008, '0, '0, "R4 pref base");
      look(6'd8, 1'b0, 32'h0, 32'h0000_D001, '0, '0, "R4 io256 base");
      look(6'd6, 1'b0, 32'h1234_5678, 32'h0, '0, '0, "R5 unimpl write");

      // R7 memory enable
      cfg_write(6'd1, 32'h0000_0002);
      look(6'd1, 1'b0, 32'h8000_1FFC, 32'h2, 6'b001010, 6'b000010, "R7 mem on");
      look(6'd1, 1'b0, 32'h8000_2000, 32'h2, 6'b001010, 6'b000000, "R9 past end");
      look(6'd1, 1'b0, 32'h9001_FFFF, 32'h2, 6'b001010, 6'b001000, "R9 pref hit");
      look(6'd1, 1'b1, 32'h8000_1000, 32'h2, 6'b001010, 6'b000000, "R9 wrong space");
      look(6'd1, 1'b0, 32'h0000_0000, 32'h2, 6'b001010, 6'b000000, "R5 unimpl no hit");

      // R7 both enabled
      cfg_write(6'd1, 32'h0000_0003);
      look(6'd4, 1'b1, 32'h0000_C0F0, 32'h0000_C0E1, 6'b011011, 6'b000001, "R7 io on");
      look(6'd8, 1'b1, 32'h0000_D0FF, 32'h0000_D001, 6'b011011, 6'b010000, "R9 io256 hit");
      look(6'd8, 1'b1, 32'h0000_D100, 32'h0000_D001, 6'b011011, 6'b000000, "R9 io256 past");

      // R8 rebase while enabled
      cfg_write(6'd5, 32'hA000_0000);
      look(6'd5, 1'b0, 32'hA000_0010, 32'hA000_0000, 6'b011011, 6'b000010, "R8 new base");
      look(6'd5, 1'b0, 32'h8000_1000, 32'hA000_0000, 6'b011011, 6'b000000, "R8 old base");

      // R6 upper half dropped, R7 memory off
      cfg_write(6'd1, 32'hFFFF_0001);
      look(6'd1, 1'b0, 32'hA000_0000, 32'h1, 6'b010001, 6'b000000, "R6 cmd upper");

      // R10 unmapped index
      cfg_write(6'd2, 32'hFFFF_FFFF);
      look(6'd2, 1'b0, 32'h0, 32'h0, 6'b010001, '0, "R10 unmapped read");
      look(6'd1, 1'b0, 32'h0, 32'h1, 6'b010001, '0, "R10 cmd untouched");
      cfg_write(6'd10, 32'hFFFF_FFFF);
      look(6'd4, 1'b0, 32'h0, 32'h0000_C0E1, 6'b010001, '0, "R10 past last bar");

      // R7 all off
      cfg_write(6'd1, 32'h0);
      look(6'd1, 1'b1, 32'h0000_C0E0, 32'h0, '0, '0, "R7 all off");

      @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule